// File: doc/BRIEF.md
# Wake-up Alarm Decision Controller

This block is a small synchronous controller that models how a sleeper reacts to an alarm. It has three states: sleeping, awake but still lying down, and up for the day. It samples an alarm signal and a working-day flag on each clock edge. Once the sleeper is up, it stays up until reset.

The block produces two versions of the same "silence the alarm" request. The first comes from a register and depends only on the state. The second is combinational and depends on the current state and the alarm input. Both are provided so that a consumer can choose between an output that is stable across the cycle and one that reacts within the same cycle. The two-bit state code is also brought out for observation, using Sleeping=00, InBed=01 and Up=10.

Top module: `wakeAlarmCtl`

## Requirements
- R1: When `rst` is high at a rising clock edge, `stateCode` becomes 00 (Sleeping) and `mooreSilence` becomes 0, whatever the alarm and working-day inputs are.
- R2: In Sleeping (00), a clock edge with `alarmIn`=0 leaves the state at 00, for either value of `weekdayIn`.
- R3: In Sleeping (00), a clock edge with `alarmIn`=1 moves the state to InBed (01).
- R4: In InBed (01), a clock edge with `alarmIn`=1 keeps the state at 01, for either value of `weekdayIn`.
- R5: In InBed (01), a clock edge with `alarmIn`=0 and `weekdayIn`=1 moves the state to Up (10).
- R6: In InBed (01), a clock edge with `alarmIn`=0 and `weekdayIn`=0 returns the state to Sleeping (00).
- R7: In Up (10), every clock edge leaves the state at 10, for all four input combinations. Only reset leaves this state.
- R8: `mooreSilence` is 1 exactly when `stateCode` is 01. It changes only at a clock edge, so a change on the inputs between edges does not move it.
- R9: `mealySilence` is 1 exactly when `alarmIn` is 1 and the state is Sleeping or InBed. It follows `alarmIn` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alarmIn | input | 1 | Alarm is sounding |
| weekdayIn | input | 1 | Today is a working day |
| mooreSilence | output | 1 | Registered silence request, high while in bed |
| mealySilence | output | 1 | Same-cycle silence request, taken from the arc |
| stateCode | output | 2 | Current state code (00 Sleeping, 01 InBed, 10 Up) |

## Verification
The block has no build parameters, so the bench instantiates it exactly as elaborated by default. With that configuration every arc of the decision graph can be reached from the ports. This includes every input combination applied in the absorbing Up state, and a reset applied while the alarm is high. The same-cycle output is sampled between clock edges, after the inputs change and before the next edge. This separates it from the registered output, which must not move in that window.

// File: rtl/wakeAlarmPkg.sv
package wakeAlarmPkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_ASLEEP = 2'b00,
    ST_IN_BED = 2'b01,
    ST_UP     = 2'b10,
    ST_SPARE  = 2'b11
  } wakeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wakeArc;   // sleeping -> in bed on alarm
    logic holdArc;   // in bed, alarm still sounding
    logic enterBed;  // next state is in bed
  } wakeStrobe_t;

endpackage

// File: rtl/wakeAlarmFsm.sv
module wakeAlarmFsm
  import wakeAlarmPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        alarm,
  input  logic        weekday,
  output wakeState_t  curState,
  output wakeStrobe_t strobe
);

  wakeState_t nextState;

  always_comb begin
    nextState = ST_ASLEEP;
    case (curState)
      ST_ASLEEP: nextState = alarm ? ST_IN_BED : ST_ASLEEP;
      ST_IN_BED: begin
        if (alarm)        nextState = ST_IN_BED;
        else if (weekday) nextState = ST_UP;
        else              nextState = ST_ASLEEP;
      end
      ST_UP:     nextState = ST_UP;
      default:   nextState = ST_ASLEEP;
    endcase
  end

  always_comb begin
    strobe.wakeArc  = (curState == ST_ASLEEP) && alarm;
    strobe.holdArc  = (curState == ST_IN_BED) && alarm;
    strobe.enterBed = (nextState == ST_IN_BED);
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_ASLEEP;
    else     curState <= nextState;
  end

endmodule

// File: rtl/wakeAlarmOut.sv
module wakeAlarmOut
  import wakeAlarmPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  wakeStrobe_t strobe,
  output logic        mooreOut,
  output logic        mealyOut
);

  always_ff @(posedge clk) begin
    if (rst) mooreOut <= 1'b0;
    else     mooreOut <= strobe.enterBed;
  end

  assign mealyOut = strobe.wakeArc | strobe.holdArc;

endmodule

// File: rtl/wakeAlarmCtl.sv
module wakeAlarmCtl
  import wakeAlarmPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         alarmIn,
  input  logic         weekdayIn,
  output logic         mooreSilence,
  output logic         mealySilence,
  output logic [1:0]   stateCode
);

  wakeState_t  curState;
  wakeStrobe_t strobe;

  wakeAlarmFsm fsmInst (
    .clk      (clk),
    .rst      (rst),
    .alarm    (alarmIn),
    .weekday  (weekdayIn),
    .curState (curState),
    .strobe   (strobe)
  );

  wakeAlarmOut outInst (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .mooreOut (mooreSilence),
    .mealyOut (mealySilence)
  );

  assign stateCode = curState;

endmodule

// File: rtl/wakeAlarmChk.sv
module wakeAlarmChk (
  input logic       clk,
  input logic       rst,
  input logic       alarmIn,
  input logic       weekdayIn,
  input logic       mooreSilence,
  input logic       mealySilence,
  input logic [1:0] stateCode
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stateCode == 2'b00 && !mooreSilence));

  a_r2_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b00 && !alarmIn) |=> stateCode == 2'b00);

  a_r3_wake: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b00 && alarmIn) |=> stateCode == 2'b01);

  a_r4_bed_hold: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b01 && alarmIn) |=> stateCode == 2'b01);

  a_r5_get_up: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b01 && !alarmIn && weekdayIn) |=> stateCode == 2'b10);

  a_r6_back_sleep: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b01 && !alarmIn && !weekdayIn) |=> stateCode == 2'b00);

  a_r7_up_absorb: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b10) |=> stateCode == 2'b10);

  a_r8_moore_match: assert property (@(posedge clk) disable iff (rst)
    mooreSilence == (stateCode == 2'b01));

  a_r9_mealy_match: assert property (@(posedge clk) disable iff (rst)
    mealySilence == (alarmIn && (stateCode == 2'b00 || stateCode == 2'b01)));

endmodule

bind wakeAlarmCtl wakeAlarmChk chkInst (
  .clk          (clk),
  .rst          (rst),
  .alarmIn      (alarmIn),
  .weekdayIn    (weekdayIn),
  .mooreSilence (mooreSilence),
  .mealySilence (mealySilence),
  .stateCode    (stateCode)
);

// File: tb/wakeAlarmCtl_test.sv
`timescale 1ns/1ps
module wakeAlarmCtl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alarmIn = 1'b0;
  logic       weekdayIn = 1'b0;
  logic       mooreSilence;
  logic       mealySilence;
  logic [1:0] stateCode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] expState;
    logic       expMoore;
    string      tag;
  } expItem_t;

  expItem_t  sbQueue[$];
  logic [1:0] modelState = 2'b00;

  always #2 clk = ~clk;

  wakeAlarmCtl uut (
    .clk          (clk),
    .rst          (rst),
    .alarmIn      (alarmIn),
    .weekdayIn    (weekdayIn),
    .mooreSilence (mooreSilence),
    .mealySilence (mealySilence),
    .stateCode    (stateCode)
  );

  function automatic logic [1:0] modelNext(logic [1:0] s, logic a, logic w, logic r);
    if (r) return 2'b00;
    case (s)
      2'b00:   return a ? 2'b01 : 2'b00;
      2'b01:   return a ? 2'b01 : (w ? 2'b10 : 2'b00);
      2'b10:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(string tag, int actual, int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // driver: applies one cycle of stimulus, checks same-cycle outputs, queues expectation
  task automatic step(logic a, logic w, logic r, string tag);
    logic [1:0] nxt;
    @(negedge clk);
    rst = r;
    alarmIn = a;
    weekdayIn = w;
    #1;
    check("R9 mealy", int'(mealySilence), int'(a && (modelState == 2'b00 || modelState == 2'b01)));
    check("R8 moore steady", int'(mooreSilence), int'(modelState == 2'b01));
    nxt = modelNext(modelState, a, w, r);
    sbQueue.push_back('{nxt, (nxt == 2'b01), tag});
    modelState = nxt;
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQueue.size() > 0) begin
        expItem_t it;
        it = sbQueue.pop_front();
        check({it.tag, " state"}, int'(stateCode), int'(it.expState));
        check({"R8 moore after ", it.tag}, int'(mooreSilence), int'(it.expMoore));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", int'(stateCode), 0);
    check("R1 reset moore", int'(mooreSilence), 0);
    step(1'b0, 1'b0, 1'b0, "R2 sleep a0w0");
    step(1'b0, 1'b1, 1'b0, "R2 sleep a0w1");
    step(1'b1, 1'b0, 1'b0, "R3 wake");
    step(1'b1, 1'b1, 1'b0, "R4 hold w1");
    step(1'b1, 1'b0, 1'b0, "R4 hold w0");
    step(1'b0, 1'b0, 1'b0, "R6 back to sleep");
    step(1'b1, 1'b1, 1'b0, "R3 wake again");
    step(1'b0, 1'b1, 1'b0, "R5 get up");
    step(1'b0, 1'b0, 1'b0, "R7 up a0w0");
    step(1'b1, 1'b0, 1'b0, "R7 up a1w0");
    step(1'b0, 1'b1, 1'b0, "R7 up a0w1");
    step(1'b1, 1'b1, 1'b0, "R7 up a1w1");
    step(1'b1, 1'b1, 1'b1, "R1 reset from up");
    step(1'b1, 1'b0, 1'b0, "R3 wake after reset");
    step(1'b1, 1'b1, 1'b1, "R1 reset from bed");
    step(1'b0, 1'b0, 1'b0, "R2 sleep after reset");
    @(negedge clk);
    alarmIn = 1'b1;
    #1;
    check("R9 mealy follows alarm", int'(mealySilence), 1);
    check("R8 moore holds between edges", int'(mooreSilence), 0);
    repeat (3) @(posedge clk);
    #1;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule